// File: doc/BRIEF.md
# Port Pin Function Controller

This block holds the per-pin configuration of a bank of general-purpose ports and turns it into pad controls. Every port carries sixteen pins. For each pin a set of one-bit settings decides three things. The first is whether the pin is a plain software port or is handed to one of eight peripheral functions. The second is which side decides the pin's direction. The third is whether the pad level may reach the inside of the chip. For every pin the block produces a registered pad output value, a registered pad output enable and a registered gated input.

Software reaches the settings through a small synchronous 16-bit bus. Each setting kind occupies its own address window, and the port number selects a word inside that window at a stride of four bytes. A read-only level window returns the gated pad levels. Peripherals present eight output/enable pairs per pin, and the 3-bit function index picks one pair.

Top module: `pinfn_ctrl`

## Requirements
- R1: After reset every direction word reads 0xFFFF (all inputs), the data, mode, all three select, input-enable, bidirectional and peripheral-direction words read 0, and every pad output enable is 0.
- R2: A setting word lives at window base + 4 × port, where the bases (bits 15:8 of the address) are 0x00 data, 0x03 direction, 0x04 mode, 0x05 select bit 0, 0x06 select bit 1, 0x0A select bit 2, 0x40 input enable, 0x41 bidirectional and 0x42 peripheral direction. Each word is written whole in one cycle and reads back the value written, and other ports are left untouched.
- R3: With mode bit 0, a direction bit of 0 drives the pad with the data bit and enables the output, and a direction bit of 1 disables the output.
- R4: With mode bit 1, the pad output is the peripheral output selected by the function index, whose bit 0, bit 1 and bit 2 come from select words 0, 1 and 2. Peripheral output and enable for pin n and function f sit at bit n × 8 + f of their vectors, where n = port × 16 + pin.
- R5: With mode bit 1, a peripheral-direction bit of 1 takes the output enable from the selected peripheral enable. A value of 0 takes it from the inverted direction bit.
- R6: A pin whose input-enable bit is 0 reads 0 in the level window (base 0x02) and on its gated input.
- R7: A pin whose output is enabled reads its pad level only when its bidirectional bit is 1. Otherwise it reads 0.
- R8: Writes to the level window change nothing.
- R9: Reads from unmapped addresses (misaligned, port 12 or above, or an unused window) return 0, and writes to them change nothing.
- R10: Read data appears one cycle after the read request and is 0 in every other cycle. Pad outputs reflect a setting one cycle after the setting register changes.
- R11: The gated input is the pad level masked by the same rule that governs the level window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 16 | Write word |
| bus_rdata | output | 16 | Read word, valid the cycle after a read |
| pad_in | input | NP×16 | Pad levels |
| pad_out | output | NP×16 | Pad output values |
| pad_oe | output | NP×16 | Pad output enables |
| pin_din | output | NP×16 | Gated pad levels for internal use |
| alt_out | input | NP×16×8 | Peripheral output per pin and function |
| alt_oe | input | NP×16×8 | Peripheral output enable per pin and function |

## Verification
A write takes effect at the clock edge that samples it. Pad output, enable and gated input follow at the next edge, two edges after the request. The bench therefore checks the pad one falling edge after a write completes, and it also checks at the completing edge that the pad has not yet moved. Read data is captured at the edge that samples the request. The monitor compares it just after that same edge against an expected word that the driver queued when it issued the read.

// File: rtl/pinfn_pkg.sv
package pinfn_pkg;
  localparam int FN_N  = 8;
  localparam int FN_W  = $clog2(FN_N);
  localparam int NWR   = 9;

  typedef enum logic [3:0] {
    K_DATA  = 4'd0,
    K_DIR   = 4'd1,
    K_MODE  = 4'd2,
    K_SEL0  = 4'd3,
    K_SEL1  = 4'd4,
    K_SEL2  = 4'd5,
    K_IBE   = 4'd6,
    K_BIDIR = 4'd7,
    K_PDC   = 4'd8,
    K_LEVEL = 4'd9,
    K_NONE  = 4'd10
  } kind_e;

  function automatic kind_e kind_of(input logic [7:0] hi);
    case (hi)
      8'h00:   return K_DATA;
      8'h02:   return K_LEVEL;
      8'h03:   return K_DIR;
      8'h04:   return K_MODE;
      8'h05:   return K_SEL0;
      8'h06:   return K_SEL1;
      8'h0A:   return K_SEL2;
      8'h40:   return K_IBE;
      8'h41:   return K_BIDIR;
      8'h42:   return K_PDC;
      default: return K_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pinfn_regs.sv
module pinfn_regs
  import pinfn_pkg::*;
#(
  parameter int NP = 12,
  parameter int PW = 16,
  localparam int NPIN = NP * PW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_en,
  input  logic            bus_we,
  input  logic [15:0]     bus_addr,
  input  logic [PW-1:0]   bus_wdata,
  input  logic [NPIN-1:0] level_flat,
  output logic [PW-1:0]   bus_rdata,
  output logic [NPIN-1:0] data_flat,
  output logic [NPIN-1:0] dir_flat,
  output logic [NPIN-1:0] mode_flat,
  output logic [NPIN-1:0] sel0_flat,
  output logic [NPIN-1:0] sel1_flat,
  output logic [NPIN-1:0] sel2_flat,
  output logic [NPIN-1:0] ibe_flat,
  output logic [NPIN-1:0] bidir_flat,
  output logic [NPIN-1:0] pdc_flat
);
  logic [PW-1:0] store [NWR][NP];

  kind_e      kind;
  logic [5:0] port_raw;
  logic       aligned;
  logic       port_ok;
  int         port_i;

  always_comb begin
    kind     = kind_of(bus_addr[15:8]);
    port_raw = bus_addr[7:2];
    aligned  = (bus_addr[1:0] == 2'b00);
    port_ok  = aligned && (int'(port_raw) < NP);
    port_i   = port_ok ? int'(port_raw) : 0;
  end

  wire wr_hit = bus_en && bus_we && port_ok && (kind != K_LEVEL) && (kind != K_NONE);
  wire rd_req = bus_en && !bus_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NWR; k++)
        for (int p = 0; p < NP; p++)
          store[k][p] <= (k == int'(K_DIR)) ? '1 : '0;
    end else if (wr_hit) begin
      store[int'(kind)][port_i] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_req || !port_ok) begin
      bus_rdata <= '0;
    end else if (kind == K_LEVEL) begin
      bus_rdata <= level_flat[port_i*PW +: PW];
    end else if (kind == K_NONE) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= store[int'(kind)][port_i];
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_flat
    assign data_flat [p*PW +: PW] = store[K_DATA ][p];
    assign dir_flat  [p*PW +: PW] = store[K_DIR  ][p];
    assign mode_flat [p*PW +: PW] = store[K_MODE ][p];
    assign sel0_flat [p*PW +: PW] = store[K_SEL0 ][p];
    assign sel1_flat [p*PW +: PW] = store[K_SEL1 ][p];
    assign sel2_flat [p*PW +: PW] = store[K_SEL2 ][p];
    assign ibe_flat  [p*PW +: PW] = store[K_IBE  ][p];
    assign bidir_flat[p*PW +: PW] = store[K_BIDIR][p];
    assign pdc_flat  [p*PW +: PW] = store[K_PDC  ][p];
  end
endmodule

// File: rtl/pinfn_pin.sv
module pinfn_pin
  import pinfn_pkg::*;
(
  input  logic            mode,
  input  logic            dir,
  input  logic            dat,
  input  logic [FN_W-1:0] fn,
  input  logic            ibe,
  input  logic            bidir,
  input  logic            pdc,
  input  logic [FN_N-1:0] alt_o,
  input  logic [FN_N-1:0] alt_e,
  input  logic            pad_lvl,
  output logic            out_c,
  output logic            oe_c,
  output logic            din_c
);
  always_comb begin
    out_c = mode ? alt_o[fn] : dat;
    oe_c  = (mode && pdc) ? alt_e[fn] : !dir;
    din_c = pad_lvl && ibe && (!oe_c || bidir);
  end
endmodule

// File: rtl/pinfn_ctrl.sv
module pinfn_ctrl
  import pinfn_pkg::*;
#(
  parameter int NP = 12,
  parameter int PW = 16,
  localparam int NPIN = NP * PW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [15:0]        bus_addr,
  input  logic [PW-1:0]      bus_wdata,
  output logic [PW-1:0]      bus_rdata,
  input  logic [NPIN-1:0]    pad_in,
  output logic [NPIN-1:0]    pad_out,
  output logic [NPIN-1:0]    pad_oe,
  output logic [NPIN-1:0]    pin_din,
  input  logic [NPIN*FN_N-1:0] alt_out,
  input  logic [NPIN*FN_N-1:0] alt_oe
);
  logic [NPIN-1:0] data_flat, dir_flat, mode_flat;
  logic [NPIN-1:0] sel0_flat, sel1_flat, sel2_flat;
  logic [NPIN-1:0] ibe_flat, bidir_flat, pdc_flat;
  logic [NPIN-1:0] out_c, oe_c, din_c;

  pinfn_regs #(.NP(NP), .PW(PW)) u_regs (
    .clk(clk), .rst(rst),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .level_flat(din_c), .bus_rdata(bus_rdata),
    .data_flat(data_flat), .dir_flat(dir_flat), .mode_flat(mode_flat),
    .sel0_flat(sel0_flat), .sel1_flat(sel1_flat), .sel2_flat(sel2_flat),
    .ibe_flat(ibe_flat), .bidir_flat(bidir_flat), .pdc_flat(pdc_flat)
  );

  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    pinfn_pin u_pin (
      .mode(mode_flat[n]), .dir(dir_flat[n]), .dat(data_flat[n]),
      .fn({sel2_flat[n], sel1_flat[n], sel0_flat[n]}),
      .ibe(ibe_flat[n]), .bidir(bidir_flat[n]), .pdc(pdc_flat[n]),
      .alt_o(alt_out[n*FN_N +: FN_N]), .alt_e(alt_oe[n*FN_N +: FN_N]),
      .pad_lvl(pad_in[n]),
      .out_c(out_c[n]), .oe_c(oe_c[n]), .din_c(din_c[n])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
      pin_din <= '0;
    end else begin
      pad_out <= out_c;
      pad_oe  <= oe_c;
      pin_din <= din_c;
    end
  end
endmodule

// File: rtl/pinfn_ctrl_chk.sv
module pinfn_ctrl_chk #(
  parameter int NPIN = 192,
  parameter int PW   = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_en,
  input logic            bus_we,
  input logic [15:0]     bus_addr,
  input logic [PW-1:0]   bus_rdata,
  input logic [NPIN-1:0] pad_in,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] pin_din,
  input logic [NPIN-1:0] mode_q,
  input logic [NPIN-1:0] dir_q,
  input logic [NPIN-1:0] ibe_q
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && bus_rdata == '0));

  p_gpio_in_r3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((pad_oe & ~$past(mode_q) & $past(dir_q)) == '0));

  p_gpio_out_r3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((~pad_oe & ~$past(mode_q) & ~$past(dir_q)) == '0));

  p_din_gate_r6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((pin_din & ~$past(ibe_q)) == '0));

  p_din_level_r11: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((pin_din & ~$past(pad_in)) == '0));

  p_misalign_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we && bus_addr[1:0] != 2'b00) |=> (bus_rdata == '0));

  p_idle_rdata_r10: assert property (@(posedge clk) disable iff (rst)
    !(bus_en && !bus_we) |=> (bus_rdata == '0));
endmodule

bind pinfn_ctrl pinfn_ctrl_chk #(.NPIN(NPIN), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pad_in(pad_in),
  .pad_oe(pad_oe), .pin_din(pin_din), .mode_q(mode_flat),
  .dir_q(dir_flat), .ibe_q(ibe_flat)
);

// File: tb/pinfn_ctrl_bench.sv
module pinfn_ctrl_bench;
  localparam int NP   = 12;
  localparam int PW   = 16;
  localparam int NPIN = NP * PW;
  localparam int FN   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic [PW-1:0] bus_rdata;
  logic [NPIN-1:0] pad_in = '0;
  logic [NPIN-1:0] pad_out, pad_oe, pin_din;
  logic [NPIN*FN-1:0] alt_out = '0, alt_oe = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [15:0] v;
    string       tag;
  } item_t;
  item_t exp_q[$];

  always #5 clk = !clk;

  pinfn_ctrl #(.NP(NP), .PW(PW)) u_pinfn_ctrl (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pin_din(pin_din),
    .alt_out(alt_out), .alt_oe(alt_oe)
  );

  function automatic logic [15:0] ad(input logic [15:0] base, input int port);
    return base + 16'(port * 4);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    it.v = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  // Monitor: read data is due just after the edge that samples the request
  always @(posedge clk) begin
    #1;
    if (!rst && bus_en && !bus_we) begin
      item_t it;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected read: actual=%0h expected=none", bus_rdata);
      end else begin
        it = exp_q.pop_front();
        check(it.tag, 32'(bus_rdata), 32'(it.v));
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 pad_oe after reset", 32'(pad_oe == '0), 32'd1);
    rd(ad(16'h0300, 0),  16'hFFFF, "R1 dir port0");
    rd(ad(16'h0300, 11), 16'hFFFF, "R1 dir port11");
    rd(ad(16'h0400, 3),  16'h0000, "R1 mode port3");
    rd(ad(16'h4000, 0),  16'h0000, "R1 ibe port0");
    rd(ad(16'h4200, 7),  16'h0000, "R1 pdc port7");

    // R2 addressing and readback
    wr(ad(16'h0000, 5), 16'hA5C3);
    rd(ad(16'h0000, 5), 16'hA5C3, "R2 data port5");
    rd(ad(16'h0000, 4), 16'h0000, "R2 data port4 untouched");
    wr(ad(16'h0A00, 2), 16'h1234);
    rd(ad(16'h0A00, 2), 16'h1234, "R2 sel2 port2");
    rd(ad(16'h0600, 2), 16'h0000, "R2 sel1 port2 untouched");

    // R3 / R10: port 5 pin 0 becomes an output
    wr(ad(16'h0300, 5), 16'hFFFE);
    check("R10 pad_oe not yet updated", 32'(pad_oe[80]), 32'd0);
    check("R10 rdata idle", 32'(bus_rdata), 32'd0);
    settle();
    check("R3 gpio output oe", 32'(pad_oe[80]), 32'd1);
    check("R3 gpio output value", 32'(pad_out[80]), 32'd1);
    check("R3 gpio input oe", 32'(pad_oe[81]), 32'd0);

    // R4 / R5: port 1 pin 3 (pin 19) function 5, peripheral direction
    alt_out[19*FN+5] = 1'b1;
    alt_oe[19*FN+5]  = 1'b1;
    wr(ad(16'h0500, 1), 16'h0008);
    wr(ad(16'h0A00, 1), 16'h0008);
    wr(ad(16'h4200, 1), 16'h0008);
    wr(ad(16'h0400, 1), 16'h0008);
    settle();
    check("R4 alt fn5 output", 32'(pad_out[19]), 32'd1);
    check("R5 alt fn5 enable", 32'(pad_oe[19]), 32'd1);
    alt_out[19*FN+5] = 1'b0;
    alt_out[19*FN+4] = 1'b1;
    settle(); settle();
    check("R4 other fn ignored", 32'(pad_out[19]), 32'd0);
    alt_oe[19*FN+5] = 1'b0;
    settle(); settle();
    check("R5 peripheral enable low", 32'(pad_oe[19]), 32'd0);

    // R5 software-directed alternate pin
    wr(ad(16'h4200, 1), 16'h0000);
    wr(ad(16'h0300, 1), 16'hFFF7);
    settle();
    check("R5 software direction drives oe", 32'(pad_oe[19]), 32'd1);
    wr(ad(16'h0300, 1), 16'hFFFF);
    settle();
    check("R5 software direction input", 32'(pad_oe[19]), 32'd0);

    // R6 / R11 input buffer gating on port 0 pin 2
    pad_in[2] = 1'b1;
    settle();
    rd(ad(16'h0200, 0), 16'h0000, "R6 level gated off");
    check("R11 pin_din gated off", 32'(pin_din[2]), 32'd0);
    wr(ad(16'h4000, 0), 16'h0004);
    rd(ad(16'h0200, 0), 16'h0004, "R6 level enabled");
    check("R11 pin_din enabled", 32'(pin_din[2]), 32'd1);

    // R7 output pin readback needs bidirectional bit (pin 80)
    pad_in[80] = 1'b1;
    wr(ad(16'h4000, 5), 16'h0001);
    rd(ad(16'h0200, 5), 16'h0000, "R7 output without bidir");
    wr(ad(16'h4100, 5), 16'h0001);
    rd(ad(16'h0200, 5), 16'h0001, "R7 output with bidir");

    // R8 level window ignores writes
    wr(ad(16'h0200, 5), 16'hFFFF);
    rd(ad(16'h0200, 5), 16'h0001, "R8 level after write");
    rd(ad(16'h0000, 5), 16'hA5C3, "R8 data unaffected");

    // R9 unmapped accesses
    rd(16'h0301, 16'h0000, "R9 misaligned read");
    rd(ad(16'h0300, 12), 16'h0000, "R9 port out of range read");
    rd(16'h0100, 16'h0000, "R9 unused window read");
    wr(16'h0301, 16'h0000);
    rd(ad(16'h0300, 0), 16'hFFFF, "R9 misaligned write ignored");
    wr(ad(16'h0300, 12), 16'h0000);
    rd(ad(16'h0300, 11), 16'hFFFF, "R9 out of range write ignored");

    settle(); settle();
    check("R10 all reads answered", 32'(exp_q.size()), 32'd0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule